// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block resolves a virtual address into a physical page mapping by reading 64-bit translation entries from memory, one level at a time. It supports three modes. With translation switched off it maps addresses one-to-one. The three-level mode is an extended physical address format with a small four-entry top table. The four-level mode covers a 48-bit virtual space. Entry reads and accessed/dirty write-backs share one request/response memory port. Only one walk is in flight at any time.

At each level the walker checks the present bit and the execute-disable bit, then sets the accessed bit in memory if it was clear. It folds the user, writable and execute-disable bits of the entries it passes through. A directory entry with the page-size bit set ends the walk early as a 2 MB page. The result carries the page frame, the page size and the folded rights, or a fault code instead. A separate protection checker judges the rights against the access. Entry bits used: present = bit 0, writable = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6, page size = bit 7, execute-disable = bit 63.

Top module: `pt_walker`

## Requirements
- R1: With `cfg_paging_en` low, a walk makes no memory request and returns fault code 0, frame = virtual address bits 31:12 followed by 12 zero bits, size 4 KB (`res_big` = 0), and rights user = 1, write = 1, execute-disable = 0.
- R2: In four-level mode (`cfg_long_mode` high), if virtual address bits 63:47 are neither all zeros nor all ones, the walk returns fault code 3 and makes no memory request. An upper-half canonical address is walked normally.
- R3: Each entry address is (table base + 8 × index) ANDed with `cfg_a20_mask`. The indices are virtual bits 47:39, 38:30, 29:21 and 20:12, from the top level down. The next table base is the entry ANDed with 0xFFFFF000. In four-level mode the first base is `cfg_root` with its low 12 bits cleared.
- R4: In three-level mode the first base is `cfg_root` with its low 5 bits cleared, and the index is virtual bits 31:30. At that level the only check is present. It restricts no rights, does not check execute-disable, and is never written back.
- R5: An entry with bit 0 clear ends the walk with fault code 1, with no write-back for that entry.
- R6: An entry with bit 63 set while `cfg_nx_en` is low ends the walk with fault code 2 (reserved bit). This applies at every level except the three-level top.
- R7: A non-leaf entry that passes its checks is written back once, as the entry with bit 5 set, if bit 5 was clear. If bit 5 was already set it is not written.
- R8: A directory-level entry (third level in four-level mode, second in three-level mode) with bit 7 set ends the walk as a 2 MB page. In that case `res_big` = 1 and the frame = entry bits 31:21 followed by 21 zero bits.
- R9: A leaf entry (4 KB or 2 MB) is written back in one write that sets bit 5, and also bit 6 when `req_write` is high. The write is made only if it changes the entry.
- R10: `res_user` is the AND of bit 2 and `res_write` the AND of bit 1 over all levels walked. `res_xd` is the OR of bit 63 over the same levels. The three-level top is excluded from all three.
- R11: `req_ready` is high only when no walk is in flight. A pending memory request holds its address, direction and data until it is accepted. A result holds stable until `res_ready` is sampled high. The result is presented only after the walk's last memory request has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_paging_en | input | 1 | Translation enabled |
| cfg_long_mode | input | 1 | 1 = four-level mode, 0 = three-level mode |
| cfg_nx_en | input | 1 | Execute-disable feature enabled |
| cfg_root | input | PA_W | Root table pointer |
| cfg_a20_mask | input | PA_W | Mask ANDed into every entry address |
| req_valid | input | 1 | Walk request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vpage | input | VA_W-12 | Virtual page number (virtual address bits 63:12) |
| req_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write-back, 0 = entry read |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read entry |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_fault | output | 2 | 0 none, 1 not present, 2 reserved bit, 3 non-canonical |
| res_frame | output | PA_W | Physical page base |
| res_big | output | 1 | 1 = 2 MB page, 0 = 4 KB page |
| res_user | output | 1 | Folded user right |
| res_write | output | 1 | Folded write right |
| res_xd | output | 1 | Folded execute-disable |

## Verification
Two things can land on the same clock edge. One is the leaf's accessed/dirty write-back under memory back-pressure. The other is the end of the walk, where a result appears whose release depends on that write being accepted. The bench drives a pseudo-random ready pattern, so write-backs are stalled for one or more cycles, and checks each accepted memory operation against the reference model's expected list in the cycle it happens. When the result appears, the expected list must already be empty. A result shown before its write-back is accepted is therefore reported, and so is a write issued twice or with changed data while stalled.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int E_PRESENT = 0;
  localparam int E_WRITE   = 1;
  localparam int E_USER    = 2;
  localparam int E_ACCESS  = 5;
  localparam int E_DIRTY   = 6;
  localparam int E_BIGPG   = 7;
  localparam int E_XD      = 63;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_ABSENT   = 2'd1,
    FLT_RSVD     = 2'd2,
    FLT_NONCANON = 2'd3
  } flt_e;

  typedef enum logic [5:0] {
    ST_IDLE  = 6'b000001,
    ST_FETCH = 6'b000010,
    ST_WAIT  = 6'b000100,
    ST_WB    = 6'b001000,
    ST_DONE  = 6'b010000,
    ST_FAULT = 6'b100000
  } walk_st_e;

  typedef struct packed {
    logic user;
    logic wr;
    logic xd;
  } rights_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int PA_W     = 32,
  parameter int LVL_BITS = 9,
  parameter int LEVELS   = 4,
  parameter int LEG_IDX  = 2,
  parameter int LEG_LSB  = 18,
  parameter int ENT_SH   = 3
) (
  input  logic [LEVELS*LVL_BITS-1:0]  vpn,
  input  logic [$clog2(LEVELS)-1:0]   lvl,
  input  logic                        long_mode,
  input  logic [PA_W-1:0]             base,
  input  logic [PA_W-1:0]             a20_mask,
  output logic [PA_W-1:0]             addr
);
  localparam int LVL_W  = $clog2(LEVELS);
  localparam int OFF_W  = LVL_BITS + ENT_SH;
  localparam logic [LVL_W-1:0] LEG_TOP = LVL_W'(LEVELS - 2);

  logic [LVL_BITS-1:0] idx_lvl [LEVELS];
  logic [LVL_BITS-1:0] idx_sel;
  logic [OFF_W-1:0]    byte_off;

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_lvl[l] = vpn[l*LVL_BITS +: LVL_BITS];
  end

  always_comb begin
    if (!long_mode && lvl == LEG_TOP) begin
      idx_sel = {{(LVL_BITS-LEG_IDX){1'b0}}, vpn[LEG_LSB +: LEG_IDX]};
    end else begin
      idx_sel = idx_lvl[lvl];
    end
    byte_off = {idx_sel, {ENT_SH{1'b0}}};
    addr     = (base + {{(PA_W-OFF_W){1'b0}}, byte_off}) & a20_mask;
  end

endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int PA_W     = 32,
  parameter int ENT_W    = 64,
  parameter int LEVELS   = 4,
  parameter int PG_SHIFT = 12,
  parameter int BIG_SH   = 21
) (
  input  logic [ENT_W-1:0]           ent,
  input  logic [$clog2(LEVELS)-1:0]  lvl,
  input  logic                       legacy_top,
  input  logic                       nx_en,
  input  logic                       is_write,
  output flt_e                       flt,
  output logic                       leaf,
  output logic                       big,
  output logic                       wb_need,
  output logic [ENT_W-1:0]           wb_data,
  output logic [PA_W-1:0]            next_base,
  output logic [PA_W-1:0]            frame
);
  localparam int LVL_W = $clog2(LEVELS);

  logic [ENT_W-1:0] set_bits;

  always_comb begin
    if (!ent[E_PRESENT]) begin
      flt = FLT_ABSENT;
    end else if (!legacy_top && ent[E_XD] && !nx_en) begin
      flt = FLT_RSVD;
    end else begin
      flt = FLT_NONE;
    end

    big  = (lvl == LVL_W'(1)) && ent[E_BIGPG];
    leaf = (lvl == LVL_W'(0)) || big;

    set_bits           = '0;
    set_bits[E_ACCESS] = 1'b1;
    set_bits[E_DIRTY]  = leaf && is_write;
    wb_data            = ent | set_bits;

    if (leaf) begin
      wb_need = (wb_data != ent);
    end else begin
      wb_need = !legacy_top && !ent[E_ACCESS];
    end

    next_base = {ent[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    frame     = big ? {ent[PA_W-1:BIG_SH], {BIG_SH{1'b0}}} : next_base;
  end

endmodule

// File: rtl/ptw_rights_acc.sv
module ptw_rights_acc
  import ptw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    init,
  input  logic    fold,
  input  logic    ent_user,
  input  logic    ent_wr,
  input  logic    ent_xd,
  output rights_t rights
);
  rights_t acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (init) begin
      acc_d = '{user: 1'b1, wr: 1'b1, xd: 1'b0};
    end else if (fold) begin
      acc_d.user = acc_q.user & ent_user;
      acc_d.wr   = acc_q.wr   & ent_wr;
      acc_d.xd   = acc_q.xd   | ent_xd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '{user: 1'b1, wr: 1'b1, xd: 1'b0};
    end else if (init || fold) begin
      acc_q <= acc_d;
    end
  end

  assign rights = acc_q;

  // R10: once cleared within a walk, user stays cleared until the next walk
  a_r10_user_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_q.user && !init) |=> !acc_q.user);

  // R10: once set within a walk, execute-disable stays set until the next walk
  a_r10_xd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q.xd && !init) |=> acc_q.xd);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int PA_W     = 32,
  parameter int ENT_W    = 64,
  parameter int LVL_BITS = 9,
  parameter int LEVELS   = 4,
  parameter int PG_SHIFT = 12,
  parameter int LEG_ALN  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_paging_en,
  input  logic                     cfg_long_mode,
  input  logic                     cfg_nx_en,
  input  logic [PA_W-1:0]          cfg_root,
  input  logic [PA_W-1:0]          cfg_a20_mask,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-PG_SHIFT-1:0] req_vpage,
  input  logic                     req_write,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_write,
  output logic [PA_W-1:0]          mem_req_addr,
  output logic [ENT_W-1:0]         mem_req_wdata,
  input  logic                     mem_rsp_valid,
  input  logic [ENT_W-1:0]         mem_rsp_data,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [1:0]               res_fault,
  output logic [PA_W-1:0]          res_frame,
  output logic                     res_big,
  output logic                     res_user,
  output logic                     res_write,
  output logic                     res_xd
);
  localparam int LVL_W    = $clog2(LEVELS);
  localparam int VPN_W    = LEVELS * LVL_BITS;
  localparam int VPG_W    = VA_W - PG_SHIFT;
  localparam int CANON_LO = VPN_W - 1;
  localparam int BIG_SH   = PG_SHIFT + LVL_BITS;
  localparam int FRM_W    = PA_W - PG_SHIFT;
  localparam int LEG_IDX  = 2;
  localparam int LEG_LSB  = FRM_W - LEG_IDX;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);
  localparam logic [LVL_W-1:0] LEG_TOP = LVL_W'(LEVELS - 2);
  localparam logic [PA_W-1:0]  PG_MASK = ~PA_W'((64'd1 << PG_SHIFT) - 64'd1);
  localparam logic [PA_W-1:0]  LEG_MASK = ~PA_W'((64'd1 << LEG_ALN) - 64'd1);

  walk_st_e state_q, state_d;

  logic [VPN_W-1:0] vpn_q;
  logic             wr_q, long_q, nx_q;
  logic [PA_W-1:0]  a20_q, base_q, nbase_q, frame_q;
  logic [LVL_W-1:0] lvl_q;
  logic [ENT_W-1:0] wbd_q;
  logic             leaf_q, big_q;
  flt_e             flt_q;

  logic             accept, rsp_en, wb_done, descend, legacy_top, noncanon;
  flt_e             ev_flt;
  logic             ev_leaf, ev_big, ev_wb;
  logic [ENT_W-1:0] ev_wbd;
  logic [PA_W-1:0]  ev_next, ev_frame, ent_addr;
  rights_t          rights;

  // ---------------------------------------------------------------- datapath
  assign accept     = (state_q == ST_IDLE) && req_valid;
  assign rsp_en     = (state_q == ST_WAIT) && mem_rsp_valid;
  assign wb_done    = (state_q == ST_WB) && mem_req_ready;
  assign legacy_top = !long_q && (lvl_q == LEG_TOP);
  assign noncanon   = !(&req_vpage[VPG_W-1:CANON_LO]) && (|req_vpage[VPG_W-1:CANON_LO]);
  assign descend    = (rsp_en && (ev_flt == FLT_NONE) && !ev_wb && !ev_leaf)
                   || (wb_done && !leaf_q);

  ptw_entry_addr #(
    .PA_W(PA_W), .LVL_BITS(LVL_BITS), .LEVELS(LEVELS),
    .LEG_IDX(LEG_IDX), .LEG_LSB(LEG_LSB), .ENT_SH(3)
  ) u_addr (
    .vpn(vpn_q), .lvl(lvl_q), .long_mode(long_q),
    .base(base_q), .a20_mask(a20_q), .addr(ent_addr)
  );

  ptw_entry_eval #(
    .PA_W(PA_W), .ENT_W(ENT_W), .LEVELS(LEVELS),
    .PG_SHIFT(PG_SHIFT), .BIG_SH(BIG_SH)
  ) u_eval (
    .ent(mem_rsp_data), .lvl(lvl_q), .legacy_top(legacy_top),
    .nx_en(nx_q), .is_write(wr_q), .flt(ev_flt), .leaf(ev_leaf),
    .big(ev_big), .wb_need(ev_wb), .wb_data(ev_wbd),
    .next_base(ev_next), .frame(ev_frame)
  );

  ptw_rights_acc u_rights (
    .clk(clk), .rst_n(rst_n), .init(accept),
    .fold(rsp_en && (ev_flt == FLT_NONE) && !legacy_top),
    .ent_user(mem_rsp_data[E_USER]), .ent_wr(mem_rsp_data[E_WRITE]),
    .ent_xd(mem_rsp_data[E_XD]), .rights(rights)
  );

  // ---------------------------------------------------------------- next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!cfg_paging_en)                 state_d = ST_DONE;
          else if (cfg_long_mode && noncanon) state_d = ST_FAULT;
          else                                state_d = ST_FETCH;
        end
      end
      ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (ev_flt != FLT_NONE) state_d = ST_FAULT;
          else if (ev_wb)         state_d = ST_WB;
          else if (ev_leaf)       state_d = ST_DONE;
          else                    state_d = ST_FETCH;
        end
      end
      ST_WB:    if (mem_req_ready) state_d = leaf_q ? ST_DONE : ST_FETCH;
      ST_DONE,
      ST_FAULT: if (res_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      vpn_q  <= req_vpage[VPN_W-1:0];
      wr_q   <= req_write;
      long_q <= cfg_long_mode;
      nx_q   <= cfg_nx_en;
      a20_q  <= cfg_a20_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      base_q <= cfg_long_mode ? (cfg_root & PG_MASK) : (cfg_root & LEG_MASK);
      lvl_q  <= cfg_long_mode ? TOP_LVL : LEG_TOP;
    end else if (descend) begin
      base_q <= rsp_en ? ev_next : nbase_q;
      lvl_q  <= lvl_q - LVL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_en) begin
      nbase_q <= ev_next;
      leaf_q  <= ev_leaf;
      wbd_q   <= ev_wbd;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      flt_q <= (cfg_paging_en && cfg_long_mode && noncanon) ? FLT_NONCANON : FLT_NONE;
    end else if (rsp_en) begin
      flt_q <= ev_flt;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      frame_q <= {req_vpage[FRM_W-1:0], {PG_SHIFT{1'b0}}};
      big_q   <= 1'b0;
    end else if (rsp_en && ev_leaf) begin
      frame_q <= ev_frame;
      big_q   <= ev_big;
    end
  end

  // ---------------------------------------------------------------- outputs
  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_FETCH) || (state_q == ST_WB);
  assign mem_req_write = (state_q == ST_WB);
  assign mem_req_addr  = ent_addr;
  assign mem_req_wdata = wbd_q;
  assign res_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign res_fault     = flt_q;
  assign res_frame     = frame_q;
  assign res_big       = big_q;
  assign res_user      = rights.user;
  assign res_write     = rights.wr;
  assign res_xd        = rights.xd;

  // ---------------------------------------------------------------- assertions
  // R11: a stalled memory request keeps its address, direction and data
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  // R11: a result is held until consumed
  a_r11_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_fault) && $stable(res_frame) && $stable(res_big)));

  // R11: an accepted walk closes the request side on the next cycle
  a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3: entry addresses are 8-byte aligned
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));

  // R9: every write-back carries the accessed bit
  a_r9_wb_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[E_ACCESS]);

  // R5: an absent entry ends the walk as a not-present fault
  a_r5_absent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rsp_valid && !mem_rsp_data[E_PRESENT]) |=>
      (res_valid && res_fault == 2'(FLT_ABSENT)));

  // R2: a non-canonical four-level request faults without memory traffic
  a_r2_noncanon: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && cfg_paging_en && cfg_long_mode && noncanon) |=>
      (res_valid && !mem_req_valid && res_fault == 2'(FLT_NONCANON)));

  // R1: with translation off the result follows the request directly
  a_r1_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_paging_en) |=>
      (res_valid && res_fault == 2'(FLT_NONE) && !mem_req_valid));

endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_paging_en, cfg_long_mode, cfg_nx_en;
  logic [31:0] cfg_root, cfg_a20_mask;
  logic        req_valid, req_ready, req_write;
  logic [51:0] req_vpage;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid, res_ready;
  logic [1:0]  res_fault;
  logic [31:0] res_frame;
  logic        res_big, res_user, res_write, res_xd;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R11";

  logic [63:0] mem [logic [31:0]];
  logic [31:0] q_addr [$];
  bit          q_wr   [$];
  logic [63:0] q_data [$];

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_paging_en(cfg_paging_en), .cfg_long_mode(cfg_long_mode),
    .cfg_nx_en(cfg_nx_en), .cfg_root(cfg_root), .cfg_a20_mask(cfg_a20_mask),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpage(req_vpage),
    .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_frame(res_frame), .res_big(res_big), .res_user(res_user),
    .res_write(res_write), .res_xd(res_xd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: expected memory traffic and expected result
  task automatic model(input logic [63:0] va, input bit wr,
                       output logic [1:0] ef, output logic [31:0] efr,
                       output bit eb, output bit eu, output bit ew, output bit ex);
    logic [31:0] base, a;
    logic [63:0] e, ne;
    int lv, idx;
    bit legacy, leaf;
    ef = 0; efr = 0; eb = 0; eu = 1; ew = 1; ex = 0;
    if (!cfg_paging_en) begin
      efr = {va[31:12], 12'h000};
      return;
    end
    if (cfg_long_mode && va[63:47] != 17'h0 && va[63:47] != 17'h1ffff) begin
      ef = 3;
      return;
    end
    if (cfg_long_mode) begin lv = 3; base = cfg_root & 32'hFFFFF000; end
    else               begin lv = 2; base = cfg_root & 32'hFFFFFFE0; end
    forever begin
      legacy = !cfg_long_mode && lv == 2;
      idx = legacy ? int'(va[31:30]) : int'((va >> (12 + 9*lv)) & 64'h1ff);
      a = (base + 32'(idx*8)) & cfg_a20_mask;
      q_addr.push_back(a); q_wr.push_back(0); q_data.push_back(64'h0);
      e = mem.exists(a) ? mem[a] : 64'h0;
      if (!e[0]) begin ef = 1; return; end
      if (!legacy && e[63] && !cfg_nx_en) begin ef = 2; return; end
      if (!legacy) begin eu &= e[2]; ew &= e[1]; ex |= e[63]; end
      leaf = (lv == 0) || (lv == 1 && e[7]);
      if (leaf) begin
        ne = e | 64'h20 | (wr ? 64'h40 : 64'h0);
        if (ne != e) begin q_addr.push_back(a); q_wr.push_back(1); q_data.push_back(ne); end
        eb  = (lv == 1);
        efr = eb ? {e[31:21], 21'h0} : {e[31:12], 12'h0};
        return;
      end
      if (!legacy && !e[5]) begin
        q_addr.push_back(a); q_wr.push_back(1); q_data.push_back(e | 64'h20);
      end
      base = e[31:0] & 32'hFFFFF000;
      lv--;
    end
  endtask

  // memory model: compares every accepted operation against the model list
  initial begin
    logic [7:0]  lfsr;
    bit          fire, f_wr, pend;
    logic [31:0] f_addr;
    logic [63:0] f_data, rdat;
    int          dly;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    lfsr = 8'hA5; pend = 0; dly = 0; rdat = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      fire = mem_req_valid && mem_req_ready;
      f_addr = mem_req_addr; f_wr = mem_req_write; f_data = mem_req_wdata;
      @(posedge clk); #1;
      mem_rsp_valid = 0;
      if (fire) begin
        if (q_addr.size() == 0) begin
          chk(0, {"R3 ", cur_tag}, "unexpected memory op addr", {32'h0, f_addr}, 64'h0);
        end else begin
          chk(f_addr == q_addr[0], {"R3 ", cur_tag}, "memory op address", {32'h0, f_addr}, {32'h0, q_addr[0]});
          chk(f_wr == q_wr[0], cur_tag, "memory op direction", 64'(f_wr), 64'(q_wr[0]));
          if (q_wr[0] && f_wr) chk(f_data == q_data[0], cur_tag, "write-back data", f_data, q_data[0]);
          void'(q_addr.pop_front()); void'(q_wr.pop_front()); void'(q_data.pop_front());
        end
        if (f_wr) mem[f_addr] = f_data;
        else begin
          pend = 1; dly = int'(lfsr[2]);
          rdat = mem.exists(f_addr) ? mem[f_addr] : 64'h0;
        end
      end
      if (pend) begin
        if (dly == 0) begin mem_rsp_valid = 1; mem_rsp_data = rdat; pend = 0; end
        else dly = 0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_req_ready = lfsr[0] | lfsr[1];
    end
  end

  task automatic run_walk(input logic [63:0] va, input bit wr, input string tag);
    logic [1:0]  ef;
    logic [31:0] efr;
    bit eb, eu, ew, ex;
    logic [1:0]  held_f;
    logic [31:0] held_fr;
    cur_tag = tag;
    model(va, wr, ef, efr, eb, eu, ew, ex);
    @(negedge clk);
    req_vpage = va[63:12]; req_write = wr; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R11", "req_ready while busy", 64'(req_ready), 64'h0);
    while (!res_valid) @(negedge clk);
    chk(q_addr.size() == 0, {"R11 ", tag}, "memory ops left at result", 64'(q_addr.size()), 64'h0);
    held_f = res_fault; held_fr = res_frame;
    repeat (2) @(negedge clk);
    chk(res_valid && res_fault == held_f && res_frame == held_fr, "R11", "result hold",
        {31'h0, res_valid, res_frame}, {31'h0, 1'b1, held_fr});
    chk(res_fault == ef, tag, "fault code", 64'(res_fault), 64'(ef));
    if (ef == 0) begin
      chk(res_frame == efr, tag, "frame", 64'(res_frame), 64'(efr));
      chk(res_big == eb, tag, "page size", 64'(res_big), 64'(eb));
      chk({res_user, res_write, res_xd} == {eu, ew, ex}, {"R10 ", tag}, "rights u/w/xd",
          64'({res_user, res_write, res_xd}), 64'({eu, ew, ex}));
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, walk hung");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [63:0] VA1 = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) | (64'd4 << 12) | 64'h123;
  localparam logic [63:0] VA_BIG = (64'd1 << 39) | (64'd2 << 30) | (64'd5 << 21) | 64'h1234;
  localparam logic [63:0] VA_ABS = (64'd1 << 39) | (64'd2 << 30) | (64'd3 << 21) | (64'd7 << 12);

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_vpage = 0; res_ready = 0;
    cfg_paging_en = 1; cfg_long_mode = 1; cfg_nx_en = 1;
    cfg_root = 32'h0000_1000; cfg_a20_mask = 32'hFFFF_FFFF;

    mem[32'h1008] = 64'h2007;
    mem[32'h2010] = 64'h3027;
    mem[32'h3018] = 64'h4007;
    mem[32'h4020] = 64'h0055_5007;
    mem[32'h3028] = 64'h8000_0000_0061_3083;
    mem[32'h4038] = 64'h0;
    mem[32'h5030] = 64'h8000_0000_0000_6001;
    mem[32'h6018] = 64'h7007;
    mem[32'h7010] = 64'h0ABC_D005;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !res_valid && !mem_req_valid, "R11", "reset state",
        64'({req_ready, res_valid, mem_req_valid}), 64'b100);

    run_walk(VA1, 0, "R7");                       // upper A set, leaf A set
    run_walk(VA1, 1, "R9");                       // only leaf dirty write
    run_walk(VA1, 1, "R7");                       // nothing to write
    run_walk(VA_BIG, 1, "R8");                    // 2 MB leaf, xd folded
    cfg_nx_en = 0;
    run_walk(VA_BIG, 0, "R6");                    // reserved-bit fault
    cfg_nx_en = 1;
    run_walk(VA_ABS, 0, "R5");                    // absent leaf
    run_walk(64'h0000_8000_0000_0000, 0, "R2");   // non-canonical
    run_walk(64'hFFFF_8000_0000_0000, 0, "R2");   // upper-half canonical, absent
    cfg_root = 32'h0010_1000; cfg_a20_mask = 32'hFFEF_FFFF;
    run_walk(VA1, 0, "R3");                       // address masking
    cfg_a20_mask = 32'hFFFF_FFFF;
    cfg_long_mode = 0; cfg_nx_en = 0; cfg_root = 32'h0000_5027;
    run_walk(64'h0000_0000_8060_2ABC, 0, "R4");   // three-level walk
    cfg_paging_en = 0;
    run_walk(64'h0000_0000_1234_5678, 1, "R1");   // translation off

    repeat (4) @(negedge clk);
    chk(q_addr.size() == 0, "R11", "no stray memory ops", 64'(q_addr.size()), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule